// File: doc/BRIEF.md
# Device-to-Memory Word Transfer Engine

This engine copies a block of 16-bit words from the data register of an attached disk-style device into DRAM without processor help. A single start pulse supplies a starting memory address and a word count. For each word the engine strobes a read from the device, latches the returned word, and then runs a row/column write cycle into DRAM at the current address. It stops after the last word and signals completion with a one-cycle pulse.

The working address and the remaining count are not kept in dedicated registers. Both sit in a two-entry counter file that has one shared increment/decrement unit. Each update is a select, modify and write-back pair of cycles, and these pairs are interleaved with the device and memory strobes. The address entry counts in bytes, so it advances twice per word. The memory word address is that byte address shifted right by one. All strobes are active high.

Top module: `dma_xfer_engine`

## Requirements
- R1: While reset is applied and after it is released, every strobe, `dram_addr`, `busy` and `done` are low until a start is accepted.
- R2: `ide_a_en` is high for exactly one cycle: the cycle right after a start with a nonzero count is accepted. The device register address is then zero, and no read strobe is active in that cycle.
- R3: For each word, `ide_rd` is high for exactly three consecutive cycles. The word on `ide_data_in` is captured at the clock edge that ends the third cycle.
- R4: Word k (k from 0) is written at word address (init_addr >> 1) + k, taken modulo 2^(2*MUX_W). The row (upper MUX_W bits) is on `dram_addr` in the cycle where `dram_ras` rises. The column (lower MUX_W bits) is on `dram_addr` while `dram_cas` is high.
- R5: While `dram_cas` is high, `dram_dq_out` carries the word captured for that iteration.
- R6: A nonzero count N gives exactly N read strobe bursts and N CAS pulses. `done` is high in cycle 8N+2 after the start edge (the first cycle after that edge counts as cycle 1). No count underflow occurs.
- R7: `done` is a one-cycle pulse. `busy` is high from cycle 1 through the `done` cycle and is low afterwards.
- R8: A start with count zero produces `done` in cycle 1 and no device or memory strobe.
- R9: A start pulse that arrives while `busy` is high is ignored. The running transfer continues unchanged.
- R10: `ide_rd` is never high in the same cycle as `dram_ras`, `dram_cas` or `dram_we`.
- R11: `dram_cas` is high only while `dram_ras`, `dram_we` and `dram_dq_oe` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled while idle |
| init_addr | input | CTR_W | Starting byte address (word address = init_addr >> 1) |
| init_cnt | input | CTR_W | Number of words to move |
| ide_data_in | input | DATA_W | Word returned by the device |
| ide_a_en | output | 1 | Device address buffers enabled, register address zero |
| ide_rd | output | 1 | Device read strobe |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_a_en | output | 1 | Memory address drivers enabled |
| dram_ras | output | 1 | Row strobe |
| dram_cas | output | 1 | Column strobe |
| dram_we | output | 1 | Write enable |
| dram_dq_oe | output | 1 | Data output enable toward memory |
| dram_dq_out | output | DATA_W | Word driven toward memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is the capture instant inside the three-cycle read strobe. A design that latches one cycle early still moves plausible data. The bench therefore drives a wrong word during the first two strobe cycles and the true word only in the last one. Ignored starts and address wrap also need targeted stimulus. A second start is pulsed in the middle of a transfer with different operands. Directed transfers begin just below a column boundary and at the top of the address space, and these are mixed with seeded random counts and addresses.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int CTR_SEL_W = 1;
    localparam logic [CTR_SEL_W-1:0] ENT_ADDR = 1'b0;
    localparam logic [CTR_SEL_W-1:0] ENT_CNT  = 1'b1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_CNT_SEL,
        ST_CNT_WB,
        ST_PTR_SEL,
        ST_PTR_WB,
        ST_ROW,
        ST_RAS,
        ST_WE,
        ST_CAS,
        ST_END
    } dmx_state_e;

    typedef struct packed {
        logic                 load;
        logic [CTR_SEL_W-1:0] ctr_sel;
        logic                 op_inc;
        logic                 op_dec;
        logic                 ctr_wb;
        logic                 ide_a_en;
        logic                 ide_rd;
        logic                 lat_addr;
        logic                 lat_data;
        logic                 dram_a_en;
        logic                 col_sel;
        logic                 ras;
        logic                 cas;
        logic                 we;
        logic                 dq_oe;
        logic                 busy;
        logic                 done;
    } dmx_ctrl_t;

endpackage

// File: rtl/dmx_ctr_file.sv
module dmx_ctr_file #(
    parameter int W     = 17,
    parameter int N_ENT = 2,
    localparam int SW   = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [N_ENT-1:0][W-1:0]     load_val,
    input  logic [SW-1:0]               sel,
    input  logic                        wr,
    input  logic [W-1:0]                wr_val,
    output logic [W-1:0]                rd_val
);

    logic [N_ENT-1:0][W-1:0] ent_d, ent_q;

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            always_comb begin
                ent_d[i] = ent_q[i];
                if (load) begin
                    ent_d[i] = load_val[i];
                end else if (wr && (sel == SW'(i))) begin
                    ent_d[i] = wr_val;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q[i] <= '0;
                end else begin
                    ent_q[i] <= ent_d[i];
                end
            end
        end
    endgenerate

    assign rd_val = ent_q[sel];

    a_r6_no_load_and_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && wr));

endmodule

// File: rtl/dmx_incdec.sv
module dmx_incdec #(
    parameter int W = 17
) (
    input  logic [W-1:0] val_in,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] val_out
);

    always_comb begin
        val_out = val_in;
        if (inc) begin
            val_out = val_in + W'(1);
        end else if (dec) begin
            val_out = val_in - W'(1);
        end
    end

    a_r6_single_op: assert final (!(inc && dec));

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      init_zero,
    input  logic      cnt_zero,
    output dmx_ctrl_t ctrl
);

    typedef struct packed {
        dmx_state_e state;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d  = r_q;
        ctrl = '0;
        ctrl.busy = (r_q.state != ST_IDLE);
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctrl.load = 1'b1;
                    r_d.state = init_zero ? ST_END : ST_DEV_ADDR;
                end
            end
            ST_DEV_ADDR: begin
                ctrl.ide_a_en = 1'b1;
                r_d.state = ST_CNT_SEL;
            end
            ST_CNT_SEL: begin
                ctrl.ctr_sel = ENT_CNT;
                ctrl.op_dec  = 1'b1;
                r_d.state = ST_CNT_WB;
            end
            ST_CNT_WB: begin
                ctrl.ctr_sel = ENT_CNT;
                ctrl.op_dec  = 1'b1;
                ctrl.ctr_wb  = 1'b1;
                ctrl.ide_rd  = 1'b1;
                r_d.state = ST_PTR_SEL;
            end
            ST_PTR_SEL: begin
                ctrl.ctr_sel  = ENT_ADDR;
                ctrl.op_inc   = 1'b1;
                ctrl.ide_rd   = 1'b1;
                ctrl.lat_addr = 1'b1;
                r_d.state = ST_PTR_WB;
            end
            ST_PTR_WB: begin
                ctrl.ctr_sel  = ENT_ADDR;
                ctrl.op_inc   = 1'b1;
                ctrl.ctr_wb   = 1'b1;
                ctrl.ide_rd   = 1'b1;
                ctrl.lat_data = 1'b1;
                r_d.state = ST_ROW;
            end
            ST_ROW: begin
                ctrl.dram_a_en = 1'b1;
                r_d.state = ST_RAS;
            end
            ST_RAS: begin
                ctrl.ctr_sel   = ENT_ADDR;
                ctrl.op_inc    = 1'b1;
                ctrl.dram_a_en = 1'b1;
                ctrl.ras       = 1'b1;
                r_d.state = ST_WE;
            end
            ST_WE: begin
                ctrl.ctr_sel   = ENT_ADDR;
                ctrl.op_inc    = 1'b1;
                ctrl.ctr_wb    = 1'b1;
                ctrl.dram_a_en = 1'b1;
                ctrl.col_sel   = 1'b1;
                ctrl.ras       = 1'b1;
                ctrl.we        = 1'b1;
                ctrl.dq_oe     = 1'b1;
                r_d.state = ST_CAS;
            end
            ST_CAS: begin
                ctrl.ctr_sel   = ENT_CNT;
                ctrl.dram_a_en = 1'b1;
                ctrl.col_sel   = 1'b1;
                ctrl.ras       = 1'b1;
                ctrl.we        = 1'b1;
                ctrl.cas       = 1'b1;
                ctrl.dq_oe     = 1'b1;
                r_d.state = cnt_zero ? ST_END : ST_CNT_SEL;
            end
            ST_END: begin
                ctrl.done = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.done |=> !ctrl.done);
    a_r3_rd_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl.ide_rd) |=> ctrl.ide_rd ##1 ctrl.ide_rd ##1 !ctrl.ide_rd);
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctrl.ide_rd && (ctrl.ras || ctrl.cas || ctrl.we)));
    a_r11_cas_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.cas |-> (ctrl.ras && ctrl.we && ctrl.dq_oe));
    a_r2_addr_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.ide_a_en |-> $past(start));
    a_r8_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.busy && start && init_zero) |=> ctrl.done);

endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dmx_pkg::*;
#(
    parameter int  MUX_W  = 8,
    parameter int  DATA_W = 16,
    localparam int CTR_W  = 2 * MUX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CTR_W-1:0]  init_addr,
    input  logic [CTR_W-1:0]  init_cnt,
    input  logic [DATA_W-1:0] ide_data_in,
    output logic              ide_a_en,
    output logic              ide_rd,
    output logic [MUX_W-1:0]  dram_addr,
    output logic              dram_a_en,
    output logic              dram_ras,
    output logic              dram_cas,
    output logic              dram_we,
    output logic              dram_dq_oe,
    output logic [DATA_W-1:0] dram_dq_out,
    output logic              busy,
    output logic              done
);

    localparam int WA_W  = CTR_W - 1;
    localparam int N_ENT = 2;

    typedef struct packed {
        logic [WA_W-1:0]   waddr;
        logic [DATA_W-1:0] word;
    } dp_regs_t;

    dmx_ctrl_t             ctrl;
    logic [CTR_W-1:0]      ctr_rd;
    logic [CTR_W-1:0]      ctr_nx;
    logic                  cnt_zero;
    logic                  init_zero;
    logic [N_ENT-1:0][CTR_W-1:0] ld_val;
    dp_regs_t              dp_d, dp_q;

    assign init_zero = (init_cnt == '0);
    assign cnt_zero  = (ctr_rd == '0);

    always_comb begin
        ld_val = '0;
        ld_val[ENT_ADDR] = init_addr;
        ld_val[ENT_CNT]  = init_cnt;
    end

    dmx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .init_zero (init_zero),
        .cnt_zero  (cnt_zero),
        .ctrl      (ctrl)
    );

    dmx_ctr_file #(
        .W     (CTR_W),
        .N_ENT (N_ENT)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctrl.load),
        .load_val (ld_val),
        .sel      (ctrl.ctr_sel),
        .wr       (ctrl.ctr_wb),
        .wr_val   (ctr_nx),
        .rd_val   (ctr_rd)
    );

    dmx_incdec #(
        .W (CTR_W)
    ) u_incdec (
        .val_in  (ctr_rd),
        .inc     (ctrl.op_inc),
        .dec     (ctrl.op_dec),
        .val_out (ctr_nx)
    );

    always_comb begin
        dp_d = dp_q;
        if (ctrl.lat_addr) begin
            dp_d.waddr = ctr_rd[CTR_W-1:1];
        end
        if (ctrl.lat_data) begin
            dp_d.word = ide_data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    always_comb begin
        dram_addr = '0;
        if (ctrl.dram_a_en) begin
            dram_addr = ctrl.col_sel ? dp_q.waddr[MUX_W-1:0]
                                     : dp_q.waddr[WA_W-1:MUX_W];
        end
    end

    assign ide_a_en    = ctrl.ide_a_en;
    assign ide_rd      = ctrl.ide_rd;
    assign dram_a_en   = ctrl.dram_a_en;
    assign dram_ras    = ctrl.ras;
    assign dram_cas    = ctrl.cas;
    assign dram_we     = ctrl.we;
    assign dram_dq_oe  = ctrl.dq_oe;
    assign dram_dq_out = dp_q.word;
    assign busy        = ctrl.busy;
    assign done        = ctrl.done;

    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ctr_wb && ctrl.op_dec && ctrl.ctr_sel == ENT_CNT) |-> !cnt_zero);
    a_r4_row_before_col: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dram_ras) |-> $past(dram_a_en) && !dram_cas);
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cas |-> $stable(dram_dq_out));

endmodule

// File: tb/sim_dma_xfer_engine.sv
module sim_dma_xfer_engine;

    localparam int MUX_W  = 8;
    localparam int DATA_W = 16;
    localparam int CTR_W  = 2 * MUX_W + 1;
    localparam int WA_W   = CTR_W - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CTR_W-1:0]  init_addr = '0;
    logic [CTR_W-1:0]  init_cnt = '0;
    logic [DATA_W-1:0] ide_data_in = '0;
    logic              ide_a_en, ide_rd, dram_a_en, dram_ras, dram_cas, dram_we;
    logic              dram_dq_oe, busy, done;
    logic [MUX_W-1:0]  dram_addr;
    logic [DATA_W-1:0] dram_dq_out;

    int tests = 0;
    int fails = 0;
    int cyc_total = 0;

    always #4 clk = ~clk;

    dma_xfer_engine #(.MUX_W(MUX_W), .DATA_W(DATA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .init_addr(init_addr),
        .init_cnt(init_cnt), .ide_data_in(ide_data_in), .ide_a_en(ide_a_en),
        .ide_rd(ide_rd), .dram_addr(dram_addr), .dram_a_en(dram_a_en),
        .dram_ras(dram_ras), .dram_cas(dram_cas), .dram_we(dram_we),
        .dram_dq_oe(dram_dq_oe), .dram_dq_out(dram_dq_out), .busy(busy),
        .done(done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] dword(input int k, input logic [DATA_W-1:0] salt);
        return DATA_W'(16'hA5C3 ^ (k * 16'h1F3B)) ^ salt;
    endfunction

    function automatic logic [WA_W-1:0] exp_waddr(input logic [CTR_W-1:0] a, input int k);
        return WA_W'((a >> 1) + k);
    endfunction

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_xfer(input logic [CTR_W-1:0] a, input int n, input bit poke);
        int exp_done = (n == 0) ? 1 : 8 * n + 2;
        int limit = exp_done + 4;
        int done_cyc = -1, done_cnt = 0, rd_run = 0, k_rd = 0, k_wr = 0;
        bit ras_prev = 0;
        logic [MUX_W-1:0] row = '0;
        logic [DATA_W-1:0] salt = DATA_W'($urandom);
        @(negedge clk);
        start = 1'b1; init_addr = a; init_cnt = CTR_W'(n);
        for (int cyc = 1; cyc <= limit; cyc++) begin
            @(negedge clk);
            // R2: address enable only in cycle 1 of a nonzero transfer
            chk(ide_a_en == (cyc == 1 && n != 0), "R2 ide_a_en", ide_a_en, (cyc == 1 && n != 0));
            if (ide_a_en) chk(!ide_rd, "R2 rd during addr", ide_rd, 0);
            // R10
            chk(!(ide_rd && (dram_ras || dram_cas || dram_we)), "R10 overlap", ide_rd, 0);
            // R7
            chk(busy == (cyc <= exp_done), "R7 busy", busy, (cyc <= exp_done));
            if (done) begin
                done_cnt++;
                if (done_cyc < 0) done_cyc = cyc;
            end
            if (ide_rd) begin
                rd_run++;
            end else if (rd_run > 0) begin
                chk(rd_run == 3, "R3 rd length", rd_run, 3);
                rd_run = 0;
                k_rd++;
            end
            if (dram_ras && !ras_prev) row = dram_addr;
            ras_prev = dram_ras;
            if (dram_cas) begin
                chk(dram_ras && dram_we && dram_dq_oe, "R11 cas qual",
                    {dram_ras, dram_we, dram_dq_oe}, 3'b111);
                chk({row, dram_addr} == exp_waddr(a, k_wr), "R4 word addr",
                    {row, dram_addr}, exp_waddr(a, k_wr));
                chk(dram_dq_out == dword(k_wr, salt), "R5 data", dram_dq_out, dword(k_wr, salt));
                k_wr++;
            end
            ide_data_in = (ide_rd && rd_run == 3) ? dword(k_rd, salt) : ~dword(k_rd, salt) ^ 16'h5A5A;
            start = 1'b0;
            if (poke && cyc == 19) begin
                start = 1'b1;
                init_addr = CTR_W'($urandom);
                init_cnt = CTR_W'(1);
            end
        end
        chk(done_cyc == exp_done, "R6/R8 done cycle", done_cyc, exp_done);
        chk(done_cnt == 1, "R7 done pulse", done_cnt, 1);
        chk(k_rd == n, n == 0 ? "R8 no reads" : "R6 read count", k_rd, n);
        chk(k_wr == n, poke ? "R9 write count" : "R6 write count", k_wr, n);
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R9 idle after", {busy, done}, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 during reset
        chk({ide_a_en, ide_rd, dram_ras, dram_cas, dram_we, dram_dq_oe, busy, done} == 0,
            "R1 in reset", {ide_a_en, ide_rd, dram_ras, dram_cas, dram_we, busy, done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({ide_a_en, ide_rd, dram_ras, dram_cas, dram_we, dram_a_en, busy, done} == 0
            && dram_addr == 0, "R1 after reset", {busy, done, dram_addr}, 0);
        run_xfer(17'h00000, 1, 1'b0);
        run_xfer(17'h00BFC, 3, 1'b0);              // R4 column wrap
        run_xfer(17'h1FFFE, 2, 1'b0);              // R4 top-of-space wrap
        run_xfer(17'h00100, 0, 1'b0);              // R8
        run_xfer(17'h00456, 5, 1'b1);              // R9
        for (int i = 0; i < 8; i++) begin
            run_xfer(CTR_W'($urandom), 1 + int'($urandom_range(0, 11)), 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule